// File: doc/BRIEF.md
# Missing Input Clock Detector

This block watches a reference oscillator clock and raises a status flag when that clock stops. It does not compare the reference against a known-good timebase. It runs a race between two counters in two clock domains. A short counter advances on the reference clock. A long counter advances on a fast clock, which keeps running from a fallback source when the reference disappears. Every wrap of the short counter sends a clear request into the fast domain and resets the long counter. If the reference is present and not too slow relative to the fast clock, the long counter never wraps. If the long counter does wrap, the reference has gone missing.

The clear request crosses domains as a toggle. The toggle passes through a synchroniser chain, and edge detection turns it into a one-cycle clear pulse. The missing-clock flag lives in the fast domain and is sticky. Only reset or an explicit clear request removes it. The detector enable follows the state "PLL active": while the enable is low, both counters stay at zero.

Top module: `clk_loss_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, that domain's state returns to zero. `clk_missing` reads 0 after reset, and reset also removes a flag that was set.
- R2: The reference counter is 7 bits wide. It advances by one on each `ref_clk` rising edge while `det_en` is high. Once every 128 edges it wraps and inverts the clear-request toggle.
- R3: The fast domain detects each change of the toggle through a two-flop synchroniser followed by an edge detector. On the following `fast_clk` edge the fast counter returns to zero, and that clear takes priority over a wrap in the same cycle.
- R4: The fast counter is 13 bits wide and advances by one on each `fast_clk` rising edge while `det_en` is high. Starting from zero with no clear, it wraps on the 8192nd edge and sets `clk_missing` on that same edge.
- R5: While the reference clock runs at a period of at most 63 fast-clock periods, `clk_missing` stays 0.
- R6: After the reference clock stops, `clk_missing` rises within 8196 fast-clock cycles.
- R7: `clk_missing` is sticky. It stays 1 when the reference clock returns, for as long as no clear request or reset occurs.
- R8: When `flag_clr` is high at a `fast_clk` edge, `clk_missing` goes to 0, unless the fast counter wraps on that same edge. A wrap wins.
- R9: While `det_en` is low, both counters are held at zero and `clk_missing` cannot rise. When `det_en` rises with no reference clock, the flag appears between 8190 and 8196 fast cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock being monitored |
| fast_clk | input | 1 | Fast clock (PLL output, with a fallback when the reference is absent) |
| rst_n | input | 1 | Active-low reset, sampled on each domain's clock edge |
| det_en | input | 1 | Detector enable, high while the PLL is active |
| flag_clr | input | 1 | Request to clear the missing-clock flag, fast-clock domain |
| clk_missing | output | 1 | Sticky missing-reference-clock status |

## Verification
The assertions take `det_en` to be quasi-static. They also take `rst_n` to be held low across several edges of both clocks, so that each domain's state is defined before any property is evaluated. `flag_clr` is taken to be a synchronous fast-domain input. The bench keeps within these limits. It drives every input at the falling edge of the fast clock, keeps the reference running through the reset window, and changes `det_en` only between scenarios.

// File: rtl/clk_loss_pkg.sv
// Shared sizing for the missing-clock detector.
// Assumes: FAST_W is large enough that one reference wrap period (in fast
// cycles) plus the synchroniser delay fits below 2**FAST_W.
package clk_loss_pkg;
    parameter int REF_W       = 7;
    parameter int FAST_W      = 13;
    parameter int SYNC_STAGES = 2;
endpackage

// File: rtl/ref_wrap_counter.sv
// Reference-domain counter. It counts reference edges and inverts a toggle
// each time it wraps. The toggle is the clear request for the fast domain.
// Assumes: en is quasi-static relative to ref_clk.
module ref_wrap_counter #(
    parameter int WIDTH = clk_loss_pkg::REF_W
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en,
    output logic req_tgl
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt;

    // Advance the counter while enabled; hold it at zero otherwise.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !en) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // Invert the clear-request toggle on every wrap.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                 req_tgl <= 1'b0;
        else if (en && cnt == TOP)  req_tgl <= ~req_tgl;
    end

    // R9
    ref_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !en |=> cnt == '0);
    // R2
    ref_tgl_wrap_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(req_tgl) |-> ($past(cnt) == TOP && $past(en)));
endmodule

// File: rtl/toggle_sync.sv
// Carries a toggle into the destination clock domain. A flop chain does the
// synchronising, and edge detection turns each change into a one-cycle pulse.
// Assumes: the source toggles no faster than once per STAGES+1 destination cycles.
module toggle_sync #(
    parameter int STAGES = clk_loss_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Shift the asynchronous toggle through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], tgl_in};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign pulse = chain[STAGES-1] ^ last_q;

    // R3
    sync_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/fast_race_counter.sv
// Fast-domain counter. A clear pulse returns it to zero. When it reaches the
// top value it raises a one-cycle wrap that marks a missing reference.
// Assumes: clr is a single-cycle pulse synchronous to clk.
module fast_race_counter #(
    parameter int WIDTH = clk_loss_pkg::FAST_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic wrap
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt;

    // A wrap counts only when no clear arrives in the same cycle.
    assign wrap = en && !clr && (cnt == TOP);

    // Count fast edges; a clear, a disable or a reset sends the count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    // R9
    fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);
    // R3
    fast_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    // R4
    fast_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);
endmodule

// File: rtl/clk_loss_detect.sv
// Missing reference clock detector, top level. The reference counter's wraps
// clear the fast counter through a toggle synchroniser. A fast-counter wrap
// sets a sticky flag, which flag_clr or reset removes.
// Assumes: det_en is quasi-static; rst_n is held over several edges of both clocks.
module clk_loss_detect #(
    parameter int REF_W       = clk_loss_pkg::REF_W,
    parameter int FAST_W      = clk_loss_pkg::FAST_W,
    parameter int SYNC_STAGES = clk_loss_pkg::SYNC_STAGES
) (
    input  logic ref_clk,
    input  logic fast_clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic flag_clr,
    output logic clk_missing
);
    logic req_tgl;
    logic clr_pulse;
    logic wrap;

    ref_wrap_counter #(.WIDTH(REF_W)) u_ref (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .en      (det_en),
        .req_tgl (req_tgl)
    );

    toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (fast_clk),
        .rst_n  (rst_n),
        .tgl_in (req_tgl),
        .pulse  (clr_pulse)
    );

    fast_race_counter #(.WIDTH(FAST_W)) u_fast (
        .clk   (fast_clk),
        .rst_n (rst_n),
        .en    (det_en),
        .clr   (clr_pulse),
        .wrap  (wrap)
    );

    // Sticky flag: a wrap sets it and takes priority over a clear request.
    always_ff @(posedge fast_clk) begin
        if (!rst_n)        clk_missing <= 1'b0;
        else if (wrap)     clk_missing <= 1'b1;
        else if (flag_clr) clk_missing <= 1'b0;
    end

    // R4
    flag_set_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        wrap |=> clk_missing);
    // R7
    flag_sticky_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (clk_missing && !flag_clr) |=> clk_missing);
    // R8
    flag_clr_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (flag_clr && !wrap) |=> !clk_missing);
    // R9
    flag_quiet_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (!det_en && !clk_missing) |=> !clk_missing);
endmodule

// File: tb/tb_clk_loss_detect.sv
module tb_clk_loss_detect;
    logic ref_clk  = 1'b0;
    logic fast_clk = 1'b0;
    logic rst_n    = 1'b0;
    logic det_en   = 1'b0;
    logic flag_clr = 1'b0;
    logic clk_missing;

    int   checks   = 0;
    int   failures = 0;
    bit   ref_run  = 1'b1;
    int   ref_half = 64;
    bit   done     = 1'b0;

    clk_loss_detect dut (
        .ref_clk     (ref_clk),
        .fast_clk    (fast_clk),
        .rst_n       (rst_n),
        .det_en      (det_en),
        .flag_clr    (flag_clr),
        .clk_missing (clk_missing)
    );

    // 125 MHz fast clock.
    initial forever #4 fast_clk = ~fast_clk;

    // Reference clock, with a programmable half period that the bench can stop.
    initial forever begin
        if (ref_run) begin
            #(ref_half) ref_clk = ~ref_clk;
        end else begin
            ref_clk = 1'b0;
            #4;
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_fast(input int n);
        repeat (n) @(negedge fast_clk);
    endtask

    // Counts fast cycles until the flag rises, up to limit.
    task automatic cycles_to_flag(input int limit, output int n);
        n = 0;
        while (!clk_missing && n < limit) begin
            @(negedge fast_clk);
            n++;
        end
    endtask

    task automatic t_reset();
        ref_run = 1; ref_half = 64; rst_n = 0; det_en = 1;
        wait_fast(40);
        check(clk_missing == 1'b0, "R1 flag low in reset", clk_missing, 0);
        rst_n = 1;
        wait_fast(2);
        check(clk_missing == 1'b0, "R1 flag low after reset", clk_missing, 0);
    endtask

    // Runs the reference at the given ratio; the flag must never rise (R2 R3 R5).
    task automatic t_ratio(input int ratio, input int cycles);
        int bad = 0;
        ref_half = ratio * 4;
        ref_run = 1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge fast_clk);
            if (clk_missing) bad++;
        end
        check(bad == 0, $sformatf("R5 R2 R3 no flag at ratio %0d", ratio), bad, 0);
    endtask

    task automatic t_loss();
        int n;
        @(negedge fast_clk);
        ref_run = 0;
        cycles_to_flag(9000, n);
        check(clk_missing && n <= 8196, "R6 flag after reference loss", n, 8196);
    endtask

    task automatic t_sticky();
        ref_half = 64; ref_run = 1;
        wait_fast(3000);
        check(clk_missing == 1'b1, "R7 flag sticky with reference back", clk_missing, 1);
    endtask

    task automatic t_clear();
        flag_clr = 1;
        @(negedge fast_clk);
        flag_clr = 0;
        check(clk_missing == 1'b0, "R8 flag cleared by request", clk_missing, 0);
        t_ratio(16, 10000);
    endtask

    task automatic t_disable();
        int n;
        det_en = 0;
        wait_fast(10);
        ref_run = 0;
        wait_fast(12000);
        check(clk_missing == 1'b0, "R9 no flag while disabled", clk_missing, 0);
        det_en = 1;
        cycles_to_flag(9000, n);
        check(clk_missing && n >= 8190 && n <= 8196, "R9 R4 flag time from enable", n, 8192);
    endtask

    task automatic t_reset_clears();
        rst_n = 0;
        ref_run = 1; ref_half = 64;
        wait_fast(40);
        rst_n = 1;
        wait_fast(2);
        check(clk_missing == 1'b0, "R1 reset removes set flag", clk_missing, 0);
    endtask

    initial begin
        t_reset();
        t_ratio(16, 10000);
        t_ratio(40, 20000);
        t_ratio(63, 26000);
        t_loss();
        t_sticky();
        t_clear();
        t_disable();
        t_reset_clears();
        done = 1;
        report();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end
endmodule